// File: doc/BRIEF.md
# Privileged Cache Invalidate Sequencer

This block carries out a discard-style cache invalidate command for a simple processor model. The pipeline presents a decoded two-byte opcode together with the current operating mode, the current privilege level and a host-intercept enable. In one clock the block decides whether the command is unrecognised, intercepted, faulted or executed. If it executes, the block walks the internal tag array one set per clock. In each step it drops the valid and dirty bits of every way of that set. Dirty data is never written back, so modified lines are lost. On the first step of the walk it sends a one-clock strobe that tells external caches to flush. It does not wait for any answer to that strobe.

The controller is a finite state machine with five states. `ST_IDLE` waits for a command. `ST_WALK` clears one set per cycle. `ST_FIN` raises the completion pulse. `ST_GP` raises a general-protection fault with code 0. `ST_ICPT` raises the mandatory intercept. The transitions are as follows. Any non-walking state moves to `ST_WALK`, `ST_GP` or `ST_ICPT` when a recognised command arrives; otherwise it returns to `ST_IDLE`. `ST_WALK` stays in `ST_WALK` until the last set index, then moves to `ST_FIN`. Because `ST_FIN` can accept a command, a new walk can start straight from the completion cycle. The tag array can be loaded through a fill port and read through a probe port. No status flag is produced or changed.

Top module: `cinv_seq`

## Requirements
- R1: A command is recognised only when `op_first` is 0x0F and `op_second` is 0x08. Any other pair causes no busy, fault, intercept or flush, and leaves the tag array unchanged.
- R2: When `host_icpt` is 1, a recognised command raises `icpt` for exactly one cycle, in the cycle after acceptance. This takes priority over every mode and privilege check. No walk or flush follows.
- R3: In protected mode (`cpu_mode` = 1), a command with `cpl` other than 0 raises `gp_fault` for one cycle, with `gp_code` = 0. No array state changes. With `cpl` = 0 the command executes.
- R4: In virtual-8086 mode (`cpu_mode` = 2), and in the reserved encoding 3, a command always raises `gp_fault` with code 0, whatever the privilege level.
- R5: In real-address mode (`cpu_mode` = 0), a command executes at any `cpl` without any exception.
- R6: An executed command holds `busy` high for exactly SETS cycles, starting in the cycle after acceptance. Each cycle clears the valid and dirty bits of all ways of one set, in ascending set order. Afterwards no line is valid or dirty, and no dirty data is preserved.
- R7: `ext_flush` is high for exactly one cycle per executed command: the first cycle in which `busy` is high.
- R8: `done` is a one-cycle pulse in the cycle right after the last `busy` cycle. It does not depend on any external acknowledge.
- R9: Commands presented while `busy` is high are ignored. A command presented in the `done` cycle is accepted.
- R10: Reset clears every valid and dirty bit. When not busy, a fill sets the addressed way valid, with its dirty bit equal to `fill_dirty`. Fills presented while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command presented this cycle |
| op_first | input | 8 | First opcode byte |
| op_second | input | 8 | Second opcode byte |
| cpu_mode | input | 2 | 0 real, 1 protected, 2 virtual-8086, 3 reserved |
| cpl | input | 2 | Current privilege level |
| host_icpt | input | 1 | Host intercept environment enabled |
| fill_en | input | 1 | Load one tag entry |
| fill_set | input | 6 | Set index for fill |
| fill_way | input | 2 | Way for fill |
| fill_dirty | input | 1 | Dirty value for fill |
| probe_set | input | 6 | Set index for probe read |
| probe_valid | output | 4 | Valid bits of the probed set |
| probe_dirty | output | 4 | Dirty bits of the probed set |
| busy | output | 1 | Invalidate walk in progress |
| done | output | 1 | One-cycle completion pulse |
| ext_flush | output | 1 | One-cycle external flush strobe |
| gp_fault | output | 1 | One-cycle general-protection fault |
| gp_code | output | 16 | Fault error code, always 0 |
| icpt | output | 1 | One-cycle mandatory intercept |

## Verification
Two events can fall in the same cycle: the completion pulse of one walk and the acceptance of the next command. The bench presents a second command exactly in the `done` cycle. It then checks that `done` is high in that cycle, and that `busy` and `ext_flush` are both high in the following cycle. It also checks that the second walk has the full length. A command and a fill issued in the middle of a walk must leave the walk length, the completion timing and the cleared array unchanged.

// File: rtl/cinv_pkg.sv
package cinv_pkg;
    typedef enum logic [1:0] {
        MODE_REAL = 2'd0,
        MODE_PROT = 2'd1,
        MODE_V86  = 2'd2,
        MODE_RSVD = 2'd3
    } cpu_mode_e;

    typedef enum logic [1:0] {
        RES_NONE,
        RES_ICPT,
        RES_GP,
        RES_RUN
    } result_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WALK,
        ST_FIN,
        ST_GP,
        ST_ICPT
    } state_e;

    localparam logic [7:0] OPC_ESC = 8'h0F;
    localparam logic [7:0] OPC_INV = 8'h08;
endpackage

// File: rtl/cinv_priv_check.sv
module cinv_priv_check
    import cinv_pkg::*;
(
    input  logic [7:0] op_a,
    input  logic [7:0] op_b,
    input  logic [1:0] mode,
    input  logic [1:0] cpl,
    input  logic       icpt_en,
    output result_e    res
);
    always_comb begin
        res = RES_NONE;
        if (op_a == OPC_ESC && op_b == OPC_INV) begin
            if (icpt_en) begin
                res = RES_ICPT;
            end else begin
                unique case (cpu_mode_e'(mode))
                    MODE_REAL: res = RES_RUN;
                    MODE_PROT: res = (cpl == 2'd0) ? RES_RUN : RES_GP;
                    MODE_V86:  res = RES_GP;
                    MODE_RSVD: res = RES_GP;
                    default:   res = RES_GP;
                endcase
            end
        end
    end
endmodule

// File: rtl/cinv_tag_array.sv
module cinv_tag_array #(
    parameter int SETS = 64,
    parameter int WAYS = 4,
    localparam int IDXW = $clog2(SETS),
    localparam int WW   = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_set,
    input  logic [WW-1:0]   wr_way,
    input  logic            wr_dirty,
    input  logic            clr_en,
    input  logic [IDXW-1:0] clr_set,
    input  logic [IDXW-1:0] rd_set,
    output logic [WAYS-1:0] rd_vld,
    output logic [WAYS-1:0] rd_dty
);
    logic [WAYS-1:0] vld [SETS];
    logic [WAYS-1:0] dty [SETS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                vld[s] <= '0;
                dty[s] <= '0;
            end
        end else begin
            if (wr_en) begin
                vld[wr_set][wr_way] <= 1'b1;
                dty[wr_set][wr_way] <= wr_dirty;
            end
            if (clr_en) begin
                vld[clr_set] <= '0;
                dty[clr_set] <= '0;
            end
        end
    end

    assign rd_vld = vld[rd_set];
    assign rd_dty = dty[rd_set];

    // R6: a cleared set holds no valid or dirty way afterwards
    p_set_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> (vld[$past(clr_set)] == '0 && dty[$past(clr_set)] == '0));
endmodule

// File: rtl/cinv_fsm.sv
module cinv_fsm
    import cinv_pkg::*;
#(
    parameter int SETS = 64,
    localparam int IDXW = $clog2(SETS),
    localparam logic [IDXW-1:0] LAST = IDXW'(SETS - 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  result_e         res,
    output logic            busy,
    output logic            done,
    output logic            ext_flush,
    output logic            gp_fault,
    output logic            icpt,
    output logic            clr_en,
    output logic [IDXW-1:0] clr_set
);
    state_e          state, nxt;
    logic [IDXW-1:0] idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else begin
            state <= nxt;
            idx   <= (state == ST_WALK && idx != LAST) ? idx + 1'b1 : '0;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_WALK: if (idx == LAST) nxt = ST_FIN;
            ST_IDLE, ST_FIN, ST_GP, ST_ICPT: begin
                nxt = ST_IDLE;
                if (cmd_valid) begin
                    unique case (res)
                        RES_RUN:  nxt = ST_WALK;
                        RES_GP:   nxt = ST_GP;
                        RES_ICPT: nxt = ST_ICPT;
                        RES_NONE: nxt = ST_IDLE;
                        default:  nxt = ST_IDLE;
                    endcase
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        busy      = (state == ST_WALK);
        done      = (state == ST_FIN);
        gp_fault  = (state == ST_GP);
        icpt      = (state == ST_ICPT);
        ext_flush = busy && (idx == '0);
        clr_en    = busy;
        clr_set   = idx;
    end

    // R7: the flush strobe lasts one cycle
    p_flush_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ext_flush |=> !ext_flush);
    // R7: every walk opens with the flush strobe
    p_flush_at_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ext_flush);
    // R8: completion follows the end of the walk
    p_done_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    // R9: a walk is not cut short by anything
    p_walk_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && idx != LAST) |=> busy);
endmodule

// File: rtl/cinv_seq.sv
module cinv_seq
    import cinv_pkg::*;
#(
    parameter int SETS = 64,
    parameter int WAYS = 4,
    localparam int IDXW = $clog2(SETS),
    localparam int WW   = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [7:0]      op_first,
    input  logic [7:0]      op_second,
    input  logic [1:0]      cpu_mode,
    input  logic [1:0]      cpl,
    input  logic            host_icpt,
    input  logic            fill_en,
    input  logic [IDXW-1:0] fill_set,
    input  logic [WW-1:0]   fill_way,
    input  logic            fill_dirty,
    input  logic [IDXW-1:0] probe_set,
    output logic [WAYS-1:0] probe_valid,
    output logic [WAYS-1:0] probe_dirty,
    output logic            busy,
    output logic            done,
    output logic            ext_flush,
    output logic            gp_fault,
    output logic [15:0]     gp_code,
    output logic            icpt
);
    result_e         res;
    logic            clr_en;
    logic [IDXW-1:0] clr_set;
    logic            fill_ok;

    cinv_priv_check u_priv (
        .op_a    (op_first),
        .op_b    (op_second),
        .mode    (cpu_mode),
        .cpl     (cpl),
        .icpt_en (host_icpt),
        .res     (res)
    );

    cinv_fsm #(.SETS(SETS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .res       (res),
        .busy      (busy),
        .done      (done),
        .ext_flush (ext_flush),
        .gp_fault  (gp_fault),
        .icpt      (icpt),
        .clr_en    (clr_en),
        .clr_set   (clr_set)
    );

    assign fill_ok = fill_en && !busy;

    cinv_tag_array #(.SETS(SETS), .WAYS(WAYS)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (fill_ok),
        .wr_set   (fill_set),
        .wr_way   (fill_way),
        .wr_dirty (fill_dirty),
        .clr_en   (clr_en),
        .clr_set  (clr_set),
        .rd_set   (probe_set),
        .rd_vld   (probe_valid),
        .rd_dty   (probe_dirty)
    );

    assign gp_code = 16'h0000;

    logic opc_hit;
    assign opc_hit = (op_first == OPC_ESC) && (op_second == OPC_INV);

    // R1: unrecognised opcode leaves the block quiet
    p_bad_opcode_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && !opc_hit) |=> !(busy || gp_fault || icpt));
    // R2: intercept wins over every other outcome
    p_icpt_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && opc_hit && host_icpt) |=> (icpt && !busy && !gp_fault));
    // R4: virtual-8086 and reserved modes always fault
    p_v86_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && opc_hit && !host_icpt && cpu_mode[1]) |=> (gp_fault && !busy));
    // R5: real mode always executes
    p_real_runs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && opc_hit && !host_icpt && cpu_mode == 2'd0) |=> (busy && ext_flush));
endmodule

// File: tb/cinv_seq_tb.sv
module cinv_seq_tb;
    localparam int SETS = 64;
    localparam int WAYS = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] op_first = 8'h00, op_second = 8'h00;
    logic [1:0] cpu_mode = 2'd0, cpl = 2'd0;
    logic       host_icpt = 1'b0;
    logic       fill_en = 1'b0;
    logic [5:0] fill_set = '0;
    logic [1:0] fill_way = '0;
    logic       fill_dirty = 1'b0;
    logic [5:0] probe_set = '0;
    logic [3:0] probe_valid, probe_dirty;
    logic       busy, done, ext_flush, gp_fault, icpt;
    logic [15:0] gp_code;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    cinv_seq #(.SETS(SETS), .WAYS(WAYS)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
        .op_first(op_first), .op_second(op_second), .cpu_mode(cpu_mode),
        .cpl(cpl), .host_icpt(host_icpt), .fill_en(fill_en),
        .fill_set(fill_set), .fill_way(fill_way), .fill_dirty(fill_dirty),
        .probe_set(probe_set), .probe_valid(probe_valid),
        .probe_dirty(probe_dirty), .busy(busy), .done(done),
        .ext_flush(ext_flush), .gp_fault(gp_fault), .gp_code(gp_code),
        .icpt(icpt)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_fill(input int s, input int w, input bit d);
        fill_en = 1'b1; fill_set = 6'(s); fill_way = 2'(w); fill_dirty = d;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic probe(input int s, output logic [3:0] v, output logic [3:0] d);
        probe_set = 6'(s);
        #1;
        v = probe_valid; d = probe_dirty;
    endtask

    // presents a command for one edge; returns just after the accept edge
    task automatic issue(input logic [7:0] a, input logic [7:0] b,
                         input logic [1:0] m, input logic [1:0] p, input bit ic);
        op_first = a; op_second = b; cpu_mode = m; cpl = p; host_icpt = ic;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0; host_icpt = 1'b0;
    endtask

    task automatic load_lines();
        do_fill(0, 0, 1'b1);
        do_fill(0, 3, 1'b0);
        do_fill(17, 2, 1'b1);
        do_fill(63, 1, 1'b1);
    endtask

    task automatic lines_intact(input string req);
        logic [3:0] v, d;
        probe(0, v, d);
        chk(v == 4'b1001 && d == 4'b0001, req, int'({v, d}), 8'h91);
        probe(63, v, d);
        chk(v == 4'b0010 && d == 4'b0010, req, int'({v, d}), 8'h22);
    endtask

    task automatic all_clear(input string req);
        logic [3:0] v, d;
        int bad = 0;
        for (int s = 0; s < SETS; s++) begin
            probe(s, v, d);
            if (v != 0 || d != 0) bad++;
        end
        chk(bad == 0, req, bad, 0);
    endtask

    task automatic t_reset();
        chk(!busy && !done && !ext_flush && !gp_fault && !icpt, "R10 reset outputs",
            int'({busy, done, ext_flush, gp_fault, icpt}), 0);
        all_clear("R10 reset array");
    endtask

    task automatic t_fill();
        logic [3:0] v, d;
        load_lines();
        probe(17, v, d);
        chk(v == 4'b0100 && d == 4'b0100, "R10 fill", int'({v, d}), 8'h44);
        lines_intact("R10 fill");
    endtask

    task automatic t_bad_opcode();
        issue(8'h0F, 8'h09, 2'd0, 2'd0, 1'b0);
        chk(!busy && !gp_fault && !icpt && !ext_flush, "R1 second byte",
            int'({busy, gp_fault, icpt, ext_flush}), 0);
        issue(8'h0E, 8'h08, 2'd0, 2'd0, 1'b1);
        chk(!busy && !gp_fault && !icpt && !ext_flush, "R1 first byte",
            int'({busy, gp_fault, icpt, ext_flush}), 0);
        @(negedge clk);
        lines_intact("R1 array");
    endtask

    task automatic t_intercept();
        issue(8'h0F, 8'h08, 2'd0, 2'd0, 1'b1);
        chk(icpt && !busy && !ext_flush && !gp_fault, "R2 intercept",
            int'({icpt, busy, ext_flush, gp_fault}), 8);
        @(negedge clk);
        chk(!icpt && !busy, "R2 pulse width", int'({icpt, busy}), 0);
        issue(8'h0F, 8'h08, 2'd2, 2'd3, 1'b1);
        chk(icpt && !gp_fault, "R2 over v86", int'({icpt, gp_fault}), 2);
        @(negedge clk);
        lines_intact("R2 array");
    endtask

    task automatic t_prot_fault();
        issue(8'h0F, 8'h08, 2'd1, 2'd3, 1'b0);
        chk(gp_fault && gp_code == 0 && !busy, "R3 cpl3 fault",
            int'({gp_fault, busy}), 2);
        @(negedge clk);
        chk(!gp_fault, "R3 pulse width", int'(gp_fault), 0);
        issue(8'h0F, 8'h08, 2'd1, 2'd1, 1'b0);
        chk(gp_fault && !busy, "R3 cpl1 fault", int'({gp_fault, busy}), 2);
        @(negedge clk);
        lines_intact("R3 array");
    endtask

    task automatic t_v86();
        issue(8'h0F, 8'h08, 2'd2, 2'd0, 1'b0);
        chk(gp_fault && gp_code == 0 && !busy, "R4 v86 cpl0",
            int'({gp_fault, busy}), 2);
        @(negedge clk);
        issue(8'h0F, 8'h08, 2'd3, 2'd0, 1'b0);
        chk(gp_fault && !busy, "R4 reserved mode", int'({gp_fault, busy}), 2);
        @(negedge clk);
        lines_intact("R4 array");
    endtask

    // follows a walk that has just been accepted; optional pokes mid-walk
    task automatic walk(input string req, input bit poke, output int len, output int flushes);
        len = 0; flushes = 0;
        while (busy && len < SETS + 4) begin
            if (ext_flush) begin
                flushes++;
                chk(len == 0, "R7 flush in first busy cycle", len, 0);
            end
            if (poke && len == 10) begin
                fill_en = 1'b1; fill_set = 6'd63; fill_way = 2'd0; fill_dirty = 1'b1;
                op_first = 8'h0F; op_second = 8'h08; cpu_mode = 2'd0; cmd_valid = 1'b1;
            end
            @(negedge clk);
            fill_en = 1'b0; cmd_valid = 1'b0;
            len++;
        end
        chk(len == SETS, {req, " walk length"}, len, SETS);
        chk(done && !busy, "R8 done after busy", int'({done, busy}), 2);
    endtask

    task automatic t_real_run();
        int len, fl;
        issue(8'h0F, 8'h08, 2'd0, 2'd3, 1'b0);
        chk(busy && !gp_fault && !icpt, "R5 real cpl3 runs",
            int'({busy, gp_fault, icpt}), 4);
        walk("R9 ignore while busy", 1'b1, len, fl);
        chk(fl == 1, "R7 one flush", fl, 1);
        @(negedge clk);
        chk(!done && !busy && !ext_flush, "R8 done width",
            int'({done, busy, ext_flush}), 0);
        all_clear("R6 R10 all cleared, busy fill ignored");
    endtask

    task automatic t_prot_run_b2b();
        int len, fl;
        load_lines();
        issue(8'h0F, 8'h08, 2'd1, 2'd0, 1'b0);
        chk(busy && ext_flush, "R3 cpl0 runs", int'({busy, ext_flush}), 3);
        walk("R6", 1'b0, len, fl);
        // in the done cycle, present the next command
        issue(8'h0F, 8'h08, 2'd0, 2'd0, 1'b0);
        chk(busy && ext_flush && !done, "R9 accept in done cycle",
            int'({busy, ext_flush, done}), 6);
        walk("R6 second", 1'b0, len, fl);
        chk(fl == 1, "R7 second flush", fl, 1);
        @(negedge clk);
        all_clear("R6 dirty discarded");
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_fill();
                t_bad_opcode();
                t_intercept();
                t_prot_fault();
                t_v86();
                t_real_run();
                t_prot_run_b2b();
            end
            begin
                repeat (20000) @(posedge clk);
                chk(1'b0, "watchdog", 0, 1);
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule